// File: doc/BRIEF.md
# Speculative Virtual-Channel and Switch Allocator

This block decides, once per clock, which input virtual channels of a router may send a flit through the crossbar and which head flits receive an output virtual channel. Virtual-channel allocation and switch allocation run side by side in the same cycle. A head flit that has no output VC yet therefore bids for the crossbar using only its target output port. If that bid wins but the VC bid of the same cycle fails, the crossbar slot is dropped, and the flit tries both steps again on a later cycle. This saves one pipeline stage for head flits when the network is lightly loaded.

Each input VC presents a valid flag, a flag saying it still needs an output VC (its head flit), a flag saying its downstream buffer has credit, and a target output port. The allocator keeps the busy or free state of every output VC. An output VC turns busy when it is granted and turns free again when its release bit is pulsed, which happens when the packet's tail leaves. Grants are registered, so they appear one clock after the requests that caused them. The crossbar datapath is outside this block.

Top module: `spec_vcsw_alloc`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every grant output and every waste flag is 0. Reset frees all output VCs and sets every round-robin pointer to index 0.
- R2: The results for the requests sampled at clock edge k appear on the outputs after edge k and stay there for exactly one cycle. Input VC j is input port j/NUM_VCS, lane j%NUM_VCS. Its port field is `req_port[j*PW +: PW]`.
- R3: An input VC can take part in switch allocation only when `req_valid` and `req_credit` are both 1. An input VC with `req_need_vc`=0 never receives a VC grant. A head (`req_need_vc`=1) with no credit can still receive a VC grant.
- R4: A valid head with credit bids for the VC and for the switch in the same cycle. If it wins both, `vc_gnt[j]` and `sw_gnt` for its input rise in the same cycle.
- R5: VC allocation gives each output port at most one head per cycle. That head receives the lowest-numbered free VC of the port, reported in `vc_gnt_id[j*VW +: VW]`. The granted VC then stays busy.
- R6: Output VC v of port p is freed by `ovc_release[p*NUM_VCS+v]`. The freed VC can be granted to requests sampled from the next edge on, not to requests sampled in the same cycle as the release.
- R7: Suppose a head wins the switch arbitration for a port but gets no VC in that cycle. Then `sw_gnt` for its input stays 0, and `sw_waste[port]` is 1.
- R8: Requests from VCs that already hold an output VC win over head requests. This applies both when an input picks one of its VCs and when an output picks one of the inputs.
- R9: Each input picks among its VCs, and each output picks among the inputs, in round-robin order starting from index 0. A pointer moves past the winner only when that grant is actually used. A cancelled grant leaves the pointer where it was.
- R10: In each cycle, at most one switch grant is given per output port and at most one per input port. `sw_gnt_ivc[i*VW +: VW]` gives the chosen lane of input i, and `sw_gnt_oport[i*PW +: PW]` gives its output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NI | Input VC has a flit at its head |
| req_need_vc | input | NI | Flit is a head still lacking an output VC |
| req_credit | input | NI | Downstream buffer credit available |
| req_port | input | NI*PW | Target output port per input VC |
| ovc_release | input | NUM_PORTS*NUM_VCS | Free an output VC (tail left) |
| vc_gnt | output | NI | Output VC granted to input VC |
| vc_gnt_id | output | NI*VW | Lane of the granted output VC |
| sw_gnt | output | NUM_PORTS | Switch grant per input port |
| sw_gnt_ivc | output | NUM_PORTS*VW | Lane that won at each input |
| sw_gnt_oport | output | NUM_PORTS*PW | Output port for each input grant |
| sw_waste | output | NUM_PORTS | Switch slot of an output port lost to a failed VC bid |

## Verification
Every result is due one clock after the requests that produce it. There is one register stage and no other latency. The bench changes inputs on the falling edge, lets one rising edge pass, and reads the outputs on the next falling edge. A release has an effect only one edge later. The release case is therefore checked twice: once with the release and the head request sampled in the same cycle, where the port must still look full, and once a cycle later, where the VC must be granted. The pointer rules are checked over runs of consecutive cycles whose winners follow from the reset pointers and from which grants were actually used.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vsa_rr_arb.sv
module vsa_rr_arb #(
  parameter int N  = 4,
  parameter int IW = vsa_pkg::idx_w(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  logic [IW-1:0] ptr;

  always_comb begin
    logic found;
    found   = 1'b0;
    gnt     = '0;
    gnt_idx = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
        gnt_idx  = IW'(idx);
      end
    end
    any = found;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv && any) begin
      if (gnt_idx == IW'(N - 1)) ptr <= '0;
      else                       ptr <= gnt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/vsa_vc_stage.sv
module vsa_vc_stage #(
  parameter int P  = 4,
  parameter int V  = 2,
  parameter int PW = vsa_pkg::idx_w(P),
  parameter int VW = vsa_pkg::idx_w(V),
  parameter int NI = P * V
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NI-1:0]   head_req,
  input  logic [NI*PW-1:0] req_port,
  input  logic [P*V-1:0]  release_ovc,
  output logic [NI-1:0]   va_won,
  output logic [NI*VW-1:0] va_id
);
  logic [P*V-1:0]  busy;
  logic [P*V-1:0]  set_ovc;
  logic [P*NI-1:0] won_flat;
  logic [P*VW-1:0] fidx_flat;

  for (genvar o = 0; o < P; o++) begin : g_port
    logic [NI-1:0] hreq;
    logic [NI-1:0] agnt;
    logic [vsa_pkg::idx_w(NI)-1:0] aidx;
    logic          aany;
    logic          free_any;
    logic [VW-1:0] fidx;
    logic [V-1:0]  fmask;

    always_comb begin
      for (int j = 0; j < NI; j++)
        hreq[j] = head_req[j] && (req_port[j*PW +: PW] == PW'(o));
    end

    always_comb begin
      free_any = 1'b0;
      fidx     = '0;
      fmask    = '0;
      for (int v = V - 1; v >= 0; v--) begin
        if (!busy[o*V + v]) begin
          free_any = 1'b1;
          fidx     = VW'(v);
        end
      end
      if (free_any && aany) fmask[fidx] = 1'b1;
    end

    vsa_rr_arb #(.N(NI)) u_va_arb (
      .clk(clk), .rst(rst), .req(hreq), .adv(free_any),
      .gnt(agnt), .gnt_idx(aidx), .any(aany)
    );

    assign won_flat[o*NI +: NI] = free_any ? agnt : '0;
    assign fidx_flat[o*VW +: VW] = fidx;
    assign set_ovc[o*V +: V]     = fmask;
  end

  always_comb begin
    va_won = '0;
    va_id  = '0;
    for (int o = 0; o < P; o++) begin
      for (int j = 0; j < NI; j++) begin
        if (won_flat[o*NI + j]) begin
          va_won[j]           = 1'b1;
          va_id[j*VW +: VW]   = fidx_flat[o*VW +: VW];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else     busy <= (busy & ~release_ovc) | set_ovc;
  end
endmodule

// File: rtl/vsa_sw_stage.sv
module vsa_sw_stage #(
  parameter int P  = 4,
  parameter int V  = 2,
  parameter int PW = vsa_pkg::idx_w(P),
  parameter int VW = vsa_pkg::idx_w(V),
  parameter int NI = P * V
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NI-1:0]    ns_req,
  input  logic [NI-1:0]    sp_req,
  input  logic [NI*PW-1:0] req_port,
  input  logic [NI-1:0]    va_won,
  output logic [P-1:0]     take,
  output logic [P*VW-1:0]  take_vc,
  output logic [P*PW-1:0]  take_port,
  output logic [P-1:0]     waste
);
  logic [P-1:0]    in_any;
  logic [P-1:0]    in_spec;
  logic [P-1:0]    in_va;
  logic [P-1:0]    used;
  logic [P*VW-1:0] in_vc_flat;
  logic [P*PW-1:0] in_port_flat;
  logic [P*P-1:0]  ogr_flat;

  for (genvar i = 0; i < P; i++) begin : g_in
    logic [V-1:0]  ns;
    logic [V-1:0]  sp;
    logic [V-1:0]  eff;
    logic [V-1:0]  g;
    logic [VW-1:0] idx;
    logic          any;

    assign ns  = ns_req[i*V +: V];
    assign sp  = sp_req[i*V +: V];
    assign eff = (|ns) ? ns : sp;

    vsa_rr_arb #(.N(V), .IW(VW)) u_in_arb (
      .clk(clk), .rst(rst), .req(eff), .adv(used[i]),
      .gnt(g), .gnt_idx(idx), .any(any)
    );

    assign in_any[i]                  = any;
    assign in_spec[i]                 = ~(|ns);
    assign in_vc_flat[i*VW +: VW]     = idx;
    assign in_port_flat[i*PW +: PW]   = req_port[(i*V + int'(idx))*PW +: PW];
    assign in_va[i]                   = va_won[i*V + int'(idx)];
  end

  for (genvar o = 0; o < P; o++) begin : g_out
    logic [P-1:0] rq_ns;
    logic [P-1:0] rq_sp;
    logic [P-1:0] eff;
    logic [P-1:0] g;
    logic [PW-1:0] idx;
    logic         any;

    always_comb begin
      for (int i = 0; i < P; i++) begin
        rq_ns[i] = in_any[i] && !in_spec[i] && (in_port_flat[i*PW +: PW] == PW'(o));
        rq_sp[i] = in_any[i] &&  in_spec[i] && (in_port_flat[i*PW +: PW] == PW'(o));
      end
    end
    assign eff = (|rq_ns) ? rq_ns : rq_sp;

    vsa_rr_arb #(.N(P), .IW(PW)) u_out_arb (
      .clk(clk), .rst(rst), .req(eff), .adv(|(g & used)),
      .gnt(g), .gnt_idx(idx), .any(any)
    );

    assign ogr_flat[o*P +: P] = g;
    assign waste[o]           = |(g & ~used);
  end

  always_comb begin
    for (int i = 0; i < P; i++) begin
      logic win;
      win = 1'b0;
      for (int o = 0; o < P; o++) win = win | ogr_flat[o*P + i];
      used[i] = win && (!in_spec[i] || in_va[i]);
    end
  end

  assign take      = used;
  assign take_vc   = in_vc_flat;
  assign take_port = in_port_flat;
endmodule

// File: rtl/spec_vcsw_alloc.sv
module spec_vcsw_alloc #(
  parameter int NUM_PORTS = 4,
  parameter int NUM_VCS   = 2,
  localparam int PW = vsa_pkg::idx_w(NUM_PORTS),
  localparam int VW = vsa_pkg::idx_w(NUM_VCS),
  localparam int NI = NUM_PORTS * NUM_VCS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NI-1:0]           req_valid,
  input  logic [NI-1:0]           req_need_vc,
  input  logic [NI-1:0]           req_credit,
  input  logic [NI*PW-1:0]        req_port,
  input  logic [NI-1:0]           ovc_release,
  output logic [NI-1:0]           vc_gnt,
  output logic [NI*VW-1:0]        vc_gnt_id,
  output logic [NUM_PORTS-1:0]    sw_gnt,
  output logic [NUM_PORTS*VW-1:0] sw_gnt_ivc,
  output logic [NUM_PORTS*PW-1:0] sw_gnt_oport,
  output logic [NUM_PORTS-1:0]    sw_waste
);
  logic [NI-1:0]           ns_req, sp_req, head_req;
  logic [NI-1:0]           va_won;
  logic [NI*VW-1:0]        va_id;
  logic [NUM_PORTS-1:0]    take, waste;
  logic [NUM_PORTS*VW-1:0] take_vc;
  logic [NUM_PORTS*PW-1:0] take_port;

  assign head_req = req_valid & req_need_vc;
  assign ns_req   = req_valid & req_credit & ~req_need_vc;
  assign sp_req   = req_valid & req_credit &  req_need_vc;

  vsa_vc_stage #(.P(NUM_PORTS), .V(NUM_VCS)) u_vc (
    .clk(clk), .rst(rst), .head_req(head_req), .req_port(req_port),
    .release_ovc(ovc_release), .va_won(va_won), .va_id(va_id)
  );

  vsa_sw_stage #(.P(NUM_PORTS), .V(NUM_VCS)) u_sw (
    .clk(clk), .rst(rst), .ns_req(ns_req), .sp_req(sp_req),
    .req_port(req_port), .va_won(va_won), .take(take),
    .take_vc(take_vc), .take_port(take_port), .waste(waste)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vc_gnt       <= '0;
      vc_gnt_id    <= '0;
      sw_gnt       <= '0;
      sw_gnt_ivc   <= '0;
      sw_gnt_oport <= '0;
      sw_waste     <= '0;
    end else begin
      vc_gnt   <= va_won;
      sw_gnt   <= take;
      sw_waste <= waste;
      for (int j = 0; j < NI; j++)
        vc_gnt_id[j*VW +: VW] <= va_won[j] ? va_id[j*VW +: VW] : '0;
      for (int i = 0; i < NUM_PORTS; i++) begin
        sw_gnt_ivc[i*VW +: VW]   <= take[i] ? take_vc[i*VW +: VW]   : '0;
        sw_gnt_oport[i*PW +: PW] <= take[i] ? take_port[i*PW +: PW] : '0;
      end
    end
  end
endmodule

// File: rtl/spec_vcsw_alloc_chk.sv
module spec_vcsw_alloc_chk #(
  parameter int P  = 4,
  parameter int V  = 2,
  parameter int PW = vsa_pkg::idx_w(P),
  parameter int VW = vsa_pkg::idx_w(V),
  parameter int NI = P * V
) (
  input logic            clk,
  input logic            rst,
  input logic [NI-1:0]   req_valid,
  input logic [NI-1:0]   req_need_vc,
  input logic [NI-1:0]   req_credit,
  input logic [NI-1:0]   vc_gnt,
  input logic [P-1:0]    sw_gnt,
  input logic [P*VW-1:0] sw_gnt_ivc,
  input logic [P*PW-1:0] sw_gnt_oport,
  input logic [P-1:0]    sw_waste
);
  logic [NI-1:0]  prev_valid, prev_need, prev_credit;
  logic [P*P-1:0] hit;
  logic [P-1:0]   sel_ok, sel_head, sel_vcg;

  always_ff @(posedge clk) begin
    prev_valid  <= req_valid;
    prev_need   <= req_need_vc;
    prev_credit <= req_credit;
  end

  always_comb begin
    for (int o = 0; o < P; o++)
      for (int i = 0; i < P; i++)
        hit[o*P + i] = sw_gnt[i] && (sw_gnt_oport[i*PW +: PW] == PW'(o));
    for (int i = 0; i < P; i++) begin
      int j;
      j = i*V + int'(sw_gnt_ivc[i*VW +: VW]);
      sel_ok[i]   = prev_valid[j] && prev_credit[j];
      sel_head[i] = prev_need[j];
      sel_vcg[i]  = vc_gnt[j];
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (sw_gnt == '0 && vc_gnt == '0 && sw_waste == '0)); // R1

  AST_VC_ONLY_HEADS: assert property (@(posedge clk) disable iff (rst)
    (vc_gnt & ~(prev_valid & prev_need)) == '0); // R3

  for (genvar i = 0; i < P; i++) begin : g_in_chk
    AST_SW_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (rst)
      sw_gnt[i] |-> sel_ok[i]); // R3
    AST_SPEC_PAIRED: assert property (@(posedge clk) disable iff (rst)
      (sw_gnt[i] && sel_head[i]) |-> sel_vcg[i]); // R4
  end

  for (genvar o = 0; o < P; o++) begin : g_out_chk
    AST_ONE_PER_OUTPUT: assert property (@(posedge clk) disable iff (rst)
      $countones(hit[o*P +: P]) <= 1); // R10
    AST_WASTE_IDLE: assert property (@(posedge clk) disable iff (rst)
      sw_waste[o] |-> (hit[o*P +: P] == '0)); // R7
  end
endmodule

bind spec_vcsw_alloc spec_vcsw_alloc_chk #(.P(NUM_PORTS), .V(NUM_VCS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_need_vc(req_need_vc),
  .req_credit(req_credit), .vc_gnt(vc_gnt), .sw_gnt(sw_gnt),
  .sw_gnt_ivc(sw_gnt_ivc), .sw_gnt_oport(sw_gnt_oport), .sw_waste(sw_waste)
);

// File: tb/spec_vcsw_alloc_test.sv
module spec_vcsw_alloc_test;
  localparam int P  = 4;
  localparam int V  = 2;
  localparam int PW = 2;
  localparam int VW = 1;
  localparam int NI = P * V;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NI-1:0]    req_valid = '0, req_need_vc = '0, req_credit = '0;
  logic [NI*PW-1:0] req_port = '0;
  logic [NI-1:0]    ovc_release = '0;
  logic [NI-1:0]    vc_gnt;
  logic [NI*VW-1:0] vc_gnt_id;
  logic [P-1:0]     sw_gnt, sw_waste;
  logic [P*VW-1:0]  sw_gnt_ivc;
  logic [P*PW-1:0]  sw_gnt_oport;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spec_vcsw_alloc #(.NUM_PORTS(P), .NUM_VCS(V)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_need_vc(req_need_vc),
    .req_credit(req_credit), .req_port(req_port), .ovc_release(ovc_release),
    .vc_gnt(vc_gnt), .vc_gnt_id(vc_gnt_id), .sw_gnt(sw_gnt),
    .sw_gnt_ivc(sw_gnt_ivc), .sw_gnt_oport(sw_gnt_oport), .sw_waste(sw_waste)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    req_valid = '0; req_need_vc = '0; req_credit = '0;
    req_port = '0; ovc_release = '0;
  endtask

  task automatic add(input int j, input bit head, input bit cred, input int port);
    req_valid[j]   = 1'b1;
    req_need_vc[j] = head;
    req_credit[j]  = cred;
    req_port[j*PW +: PW] = PW'(port);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    clr();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  function automatic int ivc(input int i);
    return int'(sw_gnt_ivc[i*VW +: VW]);
  endfunction
  function automatic int opt(input int i);
    return int'(sw_gnt_oport[i*PW +: PW]);
  endfunction
  function automatic int vid(input int j);
    return int'(vc_gnt_id[j*VW +: VW]);
  endfunction

  task automatic t_reset();
    do_reset();
    check("R1 sw_gnt after reset", int'(sw_gnt), 0);
    check("R1 vc_gnt after reset", int'(vc_gnt), 0);
    check("R1 sw_waste after reset", int'(sw_waste), 0);
  endtask

  task automatic t_body_and_credit();
    do_reset();
    clr(); add(0, 0, 1, 2); tick();
    check("R3 body sw_gnt", int'(sw_gnt), 1);
    check("R10 body oport", opt(0), 2);
    check("R3 body no vc_gnt", int'(vc_gnt), 0);
    clr(); tick();
    check("R2 grant lasts one cycle", int'(sw_gnt), 0);
    clr(); add(0, 0, 0, 2); tick();
    check("R3 no credit no sw_gnt", int'(sw_gnt), 0);
    clr(); add(0, 1, 0, 2); tick();
    check("R3 head no credit gets vc", int'(vc_gnt), 1);
    check("R3 head no credit no sw", int'(sw_gnt), 0);
  endtask

  task automatic t_spec_head();
    do_reset();
    clr(); add(3, 1, 1, 1); tick();
    check("R4 head vc_gnt", int'(vc_gnt), 8);
    check("R5 head vc id", vid(3), 0);
    check("R4 head sw_gnt same cycle", int'(sw_gnt), 2);
    check("R4 head sw lane", ivc(1), 1);
    check("R4 head oport", opt(1), 1);
    check("R4 no waste", int'(sw_waste), 0);
  endtask

  task automatic t_exhaust_release();
    do_reset();
    clr(); add(0, 1, 1, 3); tick();
    check("R5 first vc id", vid(0), 0);
    clr(); add(2, 1, 1, 3); tick();
    check("R5 second vc id", vid(2), 1);
    check("R5 second vc_gnt", int'(vc_gnt), 4);
    clr(); add(4, 1, 1, 3); tick();
    check("R7 full port no vc", int'(vc_gnt), 0);
    check("R7 full port sw cancelled", int'(sw_gnt), 0);
    check("R7 waste flag", int'(sw_waste), 8);
    clr(); add(4, 1, 1, 3); ovc_release[6] = 1'b1; tick();
    check("R6 release not same cycle", int'(vc_gnt), 0);
    check("R6 still wasted", int'(sw_waste), 8);
    clr(); add(4, 1, 1, 3); tick();
    check("R6 freed vc granted", int'(vc_gnt), 16);
    check("R6 freed vc id", vid(4), 0);
    check("R6 sw used", int'(sw_gnt), 4);
    check("R6 oport", opt(2), 3);
  endtask

  task automatic t_priority();
    do_reset();
    clr(); add(0, 0, 1, 1); add(2, 1, 1, 1); tick();
    check("R8 output prefers body", int'(sw_gnt), 1);
    check("R8 head still gets vc", int'(vc_gnt), 4);
    check("R8 lost SA not waste", int'(sw_waste), 0);
    do_reset();
    clr(); add(0, 1, 1, 2); add(1, 0, 1, 3); tick();
    check("R8 input prefers body lane", ivc(0), 1);
    check("R8 input body oport", opt(0), 3);
    check("R8 head vc granted", int'(vc_gnt), 1);
  endtask

  task automatic t_one_vc_per_port();
    do_reset();
    clr(); add(0, 1, 1, 1); add(2, 1, 1, 1); tick();
    check("R5 one vc per port", int'(vc_gnt), 1);
    check("R10 one sw per port", int'(sw_gnt), 1);
    check("R7 no waste", int'(sw_waste), 0);
  endtask

  task automatic t_rr_input();
    int exp_lane[3] = '{0, 1, 0};
    do_reset();
    for (int k = 0; k < 3; k++) begin
      clr(); add(0, 0, 1, 0); add(1, 0, 1, 1); tick();
      check("R9 input rr lane", ivc(0), exp_lane[k]);
      check("R9 input rr oport", opt(0), exp_lane[k]);
    end
  endtask

  task automatic t_rr_output();
    int exp_g[4] = '{1, 2, 4, 1};
    do_reset();
    for (int k = 0; k < 4; k++) begin
      clr(); add(0, 0, 1, 0); add(2, 0, 1, 0); add(4, 0, 1, 0); tick();
      check("R9 output rr winner", int'(sw_gnt), exp_g[k]);
    end
  endtask

  task automatic t_hold_on_waste();
    do_reset();
    clr(); add(6, 1, 1, 0); tick();
    check("R5 setup vc0", int'(vc_gnt), 64);
    clr(); add(7, 1, 1, 0); tick();
    check("R5 setup vc1", vid(7), 1);
    clr(); add(0, 1, 1, 0); add(2, 1, 1, 0); tick();
    check("R7 waste on full port", int'(sw_waste), 1);
    check("R7 no sw grant", int'(sw_gnt), 0);
    clr(); add(0, 0, 1, 0); add(2, 0, 1, 0); tick();
    check("R9 pointer held after waste", int'(sw_gnt), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_body_and_credit();
    t_spec_head();
    t_exhaust_release();
    t_priority();
    t_one_vc_per_port();
    t_rr_input();
    t_rr_output();
    t_hold_on_waste();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule